// File: doc/BRIEF.md
# I2C Target with Count-Prefixed Read Responses

This block is a target-only I2C endpoint that sits between an external bus controller and a host-side logic domain. Bytes the controller writes are queued in a receive FIFO for the host to drain. Bytes the host wants to hand out are queued in a transmit FIFO. When the controller reads, the answer always opens with a single byte that gives the number of queued bytes that follow, and then those bytes follow.

The block samples SCL and SDA on the system clock through two-stage synchronizers. It detects START and STOP from SDA edges while SCL is high, and pulls SDA low through an output-enable. Its 7-bit bus address can be rewritten by the host and comes out of reset at 0x28. Until the host raises the enable, all bus activity is ignored. Clock stretching, 10-bit addressing and multi-controller arbitration are not provided.

Top module: `i2c_lr_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, the receive FIFO is empty and the bus address is 0x28.
- R2: While `en` is 0 the block never drives SDA and queues no byte, whatever the bus carries.
- R3: A pulse on `addr_we` loads `addr_wdata` as the new bus address; afterwards only the new address is acknowledged.
- R4: An address byte whose upper seven bits differ from the bus address is not acknowledged, and SDA stays released until the next START, even if later bytes look like a matching address.
- R5: An address byte with bit 0 = 0 (write) that matches is acknowledged, and every following data byte is acknowledged and pushed into the receive FIFO in bus order.
- R6: An address byte with bit 0 = 1 (read) that matches is acknowledged. The first byte returned is the transmit FIFO occupancy at that acknowledge, capped at 255. Exactly that many bytes follow, in FIFO order, each popped once.
- R7: A byte requested beyond the announced count is returned as 0xFF and pops nothing. Bytes the host queues after the count was fixed stay queued for the next read.
- R8: A written data byte that arrives while the receive FIFO is full is not acknowledged and is dropped.
- R9: A repeated START, even in the middle of a byte, restarts the address phase. A STOP ends the transaction, so bits clocked afterwards without a START get no response.
- R10: While enabled, the block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Host enable; 0 keeps the block off the bus |
| addr_we | input | 1 | Load strobe for the bus address |
| addr_wdata | input | 7 | New bus address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_pop | input | 1 | Host removes the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| rx_full | output | 1 | Receive FIFO holds no free slot |
| tx_push | input | 1 | Host appends `tx_data` to the transmit FIFO |
| tx_data | input | 8 | Byte to append |
| tx_full | output | 1 | Transmit FIFO holds no free slot |

## Verification
The hardest state to reach is a read whose announced count is already fixed while the transmit FIFO keeps changing. The bench pushes an extra byte just after the address acknowledge and then reads past the count. It checks that the filler bytes are 0xFF and that the late byte is still the whole payload of the next read. A second hard corner is a repeated START placed three bits into a byte, which must discard the partial byte and produce no queued data. The bench also sweeps all 127 wrong addresses, each followed by a byte that looks like the right address.

// File: rtl/i2c_lr_pkg.sv
// Shared definitions for the count-prefixed I2C target.
// Assumes 8-bit bus bytes; the transaction state encoding is local to the engine.
package i2c_lr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } txn_state_e;

endpackage

// File: rtl/i2c_lr_bus_sync.sv
// Synchronizes SCL and SDA into the clock domain and derives bus events.
// Assumes the bus lines are idle-high and that each SCL phase lasts several clocks.
module i2c_lr_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    // Two synchronizer stages plus one history stage per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    // Event decode between the current and previous synchronized samples.
    always_comb begin
        scl_rise  = scl_pipe[1] & ~scl_pipe[2];
        scl_fall  = ~scl_pipe[1] & scl_pipe[2];
        sda_lvl   = sda_pipe[1];
        start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
        stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];
    end

endmodule

// File: rtl/i2c_lr_fifo.sv
// Show-ahead FIFO: dout is the oldest entry whenever count is non-zero.
// Assumes DEPTH >= 2; a push while full and a pop while empty are dropped.
module i2c_lr_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        do_push = push && (32'(count) < DEPTH);
        do_pop  = pop && (count != '0);
        dout    = mem[rd_ptr];
    end

    // Storage write, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/i2c_lr_engine.sv
// Transaction engine: address match, write queuing, count-prefixed reads.
// Assumes bus events from i2c_lr_bus_sync; updates SDA only on a detected SCL fall,
// except when START, STOP or disable abort the transaction.
module i2c_lr_engine
    import i2c_lr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [6:0]        own_addr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_wdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [BYTE_W-1:0] tx_head,
    output logic              tx_pop,
    output logic              sda_oe
);
    txn_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] promised;
    logic [BYTE_W-1:0] sent;
    logic              is_read;
    logic              ctrl_ack;
    logic [BYTE_W-1:0] len_now;
    logic              have_data;
    logic [BYTE_W-1:0] next_byte;

    // Count byte snapshot and selection of the next outgoing data byte.
    always_comb begin
        len_now   = (32'(tx_count) > 32'd255) ? 8'hFF : 8'(tx_count);
        have_data = sent < promised;
        next_byte = have_data ? tx_head : FILL_BYTE;
    end

    // Bus transaction state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            promised <= '0;
            sent     <= '0;
            is_read  <= 1'b0;
            ctrl_ack <= 1'b0;
            rx_push  <= 1'b0;
            rx_wdata <= '0;
            tx_pop   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            tx_pop  <= 1'b0;
            if (!en || stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            bit_cnt <= '0;
                            if (rx_sh[7:1] == own_addr) begin
                                sda_oe   <= 1'b1;
                                is_read  <= rx_sh[0];
                                promised <= len_now;
                                sent     <= '0;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                tx_sh  <= promised;
                                sda_oe <= ~promised[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            bit_cnt <= '0;
                            state   <= ST_WR_ACK;
                            if (!rx_full) begin
                                rx_push  <= 1'b1;
                                rx_wdata <= rx_sh;
                                sda_oe   <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BITS_PER_BYTE) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                                state   <= ST_RD_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            ctrl_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (!ctrl_ack) begin
                                state <= ST_SKIP;
                            end else begin
                                if (have_data) begin
                                    tx_pop <= 1'b1;
                                    sent   <= sent + 1'b1;
                                end
                                tx_sh  <= next_byte;
                                sda_oe <= ~next_byte[7];
                                state  <= ST_RD;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_lr_slave.sv
// Top of the count-prefixed I2C target: bus front end, engine and two FIFOs.
// Assumes open-drain SDA is modelled by sda_oe and that SCL is never held by this block.
module i2c_lr_slave
    import i2c_lr_pkg::*;
#(
    parameter int         FIFO_DEPTH = 16,
    parameter logic [6:0] RESET_ADDR = 7'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              addr_we,
    input  logic [6:0]        addr_wdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_full,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [6:0]        own_addr;
    logic              scl_rise;
    logic              scl_fall;
    logic              sda_lvl;
    logic              start_det;
    logic              stop_det;
    logic              rx_push;
    logic [BYTE_W-1:0] rx_wdata;
    logic [CNT_W-1:0]  rx_count;
    logic              tx_pop;
    logic [BYTE_W-1:0] tx_head;
    logic [CNT_W-1:0]  tx_count;

    // Host-writable bus address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       own_addr <= RESET_ADDR;
        else if (addr_we) own_addr <= addr_wdata;
    end

    // FIFO status flags from occupancy.
    always_comb begin
        rx_empty = (rx_count == '0);
        rx_full  = (32'(rx_count) == FIFO_DEPTH);
        tx_full  = (32'(tx_count) == FIFO_DEPTH);
    end

    i2c_lr_bus_sync u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_lr_engine #(.CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .own_addr  (own_addr),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rx_full   (rx_full),
        .rx_push   (rx_push),
        .rx_wdata  (rx_wdata),
        .tx_count  (tx_count),
        .tx_head   (tx_head),
        .tx_pop    (tx_pop),
        .sda_oe    (sda_oe)
    );

    i2c_lr_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_wdata),
        .pop   (rx_pop),
        .dout  (rx_data),
        .count (rx_count)
    );

    i2c_lr_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (tx_data),
        .pop   (tx_pop),
        .dout  (tx_head),
        .count (tx_count)
    );

endmodule

// File: rtl/i2c_lr_checker.sv
// Protocol and queue properties for i2c_lr_slave, attached by bind.
// Assumes a legal bus: the controller never raises SCL within a few clocks of lowering it.
module i2c_lr_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             rx_push,
    input logic             rx_full,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_count
);
    // R1: first cycle out of reset leaves SDA released.
    p_release_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !sda_oe);

    // R2: a disabled block lets go of SDA on the next cycle.
    p_release_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sda_oe);

    // R8: a write byte is never queued into a full receive FIFO.
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R7: only real queued bytes are popped, filler bytes pop nothing.
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_count != '0));

    // R6: each outgoing byte pops at most one entry.
    p_single_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    // R10: SDA drive changes only while SCL is low.
    p_sda_change_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (sda_oe != $past(sda_oe))) |-> !scl_i);

endmodule

bind i2c_lr_slave i2c_lr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .rx_push  (rx_push),
    .rx_full  (rx_full),
    .tx_pop   (tx_pop),
    .tx_count (tx_count)
);

// File: tb/sim_i2c_lr_slave.sv
module sim_i2c_lr_slave;
    localparam int Q     = 6;
    localparam int DEPTH = 4;
    localparam logic [6:0] DEF_ADDR = 7'h28;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       addr_we = 1'b0;
    logic [6:0] addr_wdata = '0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       sda_bus;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_empty;
    logic       rx_full;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_full;
    int n_chk = 0;
    int n_err = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_lr_slave #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full)
    );

    // R10 monitor: SDA drive must not move while the controller holds SCL high.
    always @(posedge clk) begin
        if (rst_n && en && (sda_oe !== prev_oe) && m_scl) r10_viol <= r10_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((s * 53 + k * 29 + 7) & 255);
    endfunction

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; hold();
        m_scl = 1'b1; hold(); hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        b = sda_bus; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = (b == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic host_push(input logic [7:0] v);
        @(negedge clk); tx_data = v; tx_push = 1'b1;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic host_pop(output logic [7:0] v);
        @(negedge clk); v = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int ack;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 rx_empty after reset", int'(rx_empty), 1);

        // R2: disabled block ignores a matching write.
        bus_start();
        send_byte({DEF_ADDR, 1'b0}, ack);
        chk("R2 no address ack while disabled", ack, 0);
        send_byte(8'h33, ack);
        chk("R2 no data ack while disabled", ack, 0);
        bus_stop();
        chk("R2 nothing queued while disabled", int'(rx_empty), 1);

        en = 1'b1; hold();

        // R5/R1: writes of 1..DEPTH bytes to the reset address.
        for (int n = 1; n <= DEPTH; n++) begin
            bus_start();
            send_byte({DEF_ADDR, 1'b0}, ack);
            chk("R1 reset address 0x28 acknowledged", ack, 1);
            for (int k = 0; k < n; k++) begin
                send_byte(pat(n, k), ack);
                chk("R5 data byte ack", ack, 1);
            end
            bus_stop();
            for (int k = 0; k < n; k++) begin
                chk("R5 rx not empty", int'(rx_empty), 0);
                host_pop(v);
                chk("R5 rx byte order", int'(v), int'(pat(n, k)));
            end
            chk("R5 rx drained", int'(rx_empty), 1);
        end

        // R4: every other address is refused; a look-alike byte after it is ignored.
        for (int a = 0; a < 128; a++) begin
            if (a != int'(DEF_ADDR)) begin
                bus_start();
                send_byte({7'(a), 1'b0}, ack);
                chk("R4 mismatched address nack", ack, 0);
                send_byte({DEF_ADDR, 1'b0}, ack);
                chk("R4 released until next START", ack, 0);
                bus_stop();
            end
        end
        chk("R4 nothing queued", int'(rx_empty), 1);

        // R3: address reprogramming.
        @(negedge clk); addr_wdata = 7'h5A; addr_we = 1'b1;
        @(negedge clk); addr_we = 1'b0;
        bus_start(); send_byte({7'h5A, 1'b0}, ack); bus_stop();
        chk("R3 new address acknowledged", ack, 1);
        bus_start(); send_byte({DEF_ADDR, 1'b0}, ack); bus_stop();
        chk("R3 old address refused", ack, 0);
        @(negedge clk); addr_wdata = DEF_ADDR; addr_we = 1'b1;
        @(negedge clk); addr_we = 1'b0;

        // R6: reads with 0..DEPTH queued bytes.
        for (int n = 0; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) host_push(pat(n + 10, k));
            bus_start();
            send_byte({DEF_ADDR, 1'b1}, ack);
            chk("R6 read address ack", ack, 1);
            recv_byte(v, n != 0);
            chk("R6 count byte", int'(v), n);
            for (int k = 0; k < n; k++) begin
                recv_byte(v, k != n - 1);
                chk("R6 payload byte", int'(v), int'(pat(n + 10, k)));
            end
            bus_stop();
            bus_start();
            send_byte({DEF_ADDR, 1'b1}, ack);
            recv_byte(v, 1'b0);
            bus_stop();
            chk("R6 queue drained by read", int'(v), 0);
        end

        // R7: over-read returns filler and leaves late bytes queued.
        host_push(8'hA0); host_push(8'hA1);
        bus_start();
        send_byte({DEF_ADDR, 1'b1}, ack);
        host_push(8'h5C);
        recv_byte(v, 1'b1); chk("R7 count fixed at address ack", int'(v), 2);
        recv_byte(v, 1'b1); chk("R7 payload 0", int'(v), 8'hA0);
        recv_byte(v, 1'b1); chk("R7 payload 1", int'(v), 8'hA1);
        recv_byte(v, 1'b1); chk("R7 filler 0xFF", int'(v), 8'hFF);
        recv_byte(v, 1'b0); chk("R7 filler 0xFF again", int'(v), 8'hFF);
        bus_stop();
        bus_start();
        send_byte({DEF_ADDR, 1'b1}, ack);
        recv_byte(v, 1'b1); chk("R7 late byte still queued", int'(v), 1);
        recv_byte(v, 1'b0); chk("R7 late byte value", int'(v), 8'h5C);
        bus_stop();

        // R8: receive FIFO overflow.
        bus_start();
        send_byte({DEF_ADDR, 1'b0}, ack);
        for (int k = 0; k <= DEPTH; k++) begin
            send_byte(pat(40, k), ack);
            chk("R8 ack only while space", ack, (k < DEPTH) ? 1 : 0);
        end
        bus_stop();
        for (int k = 0; k < DEPTH; k++) begin
            host_pop(v);
            chk("R8 kept bytes", int'(v), int'(pat(40, k)));
        end
        chk("R8 overflow byte dropped", int'(rx_empty), 1);

        // R9: repeated START three bits into a byte restarts the address phase.
        bus_start();
        send_byte({DEF_ADDR, 1'b0}, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte({DEF_ADDR, 1'b0}, ack);
        chk("R9 address after repeated START", ack, 1);
        send_byte(8'h6E, ack);
        bus_stop();
        host_pop(v);
        chk("R9 only the full byte queued", int'(v), 8'h6E);
        chk("R9 partial byte discarded", int'(rx_empty), 1);

        // R9: write then repeated START into a read.
        host_push(8'h91);
        bus_start();
        send_byte({DEF_ADDR, 1'b0}, ack);
        send_byte(8'h27, ack);
        bus_start();
        send_byte({DEF_ADDR, 1'b1}, ack);
        chk("R9 read after repeated START", ack, 1);
        recv_byte(v, 1'b1); chk("R9 count", int'(v), 1);
        recv_byte(v, 1'b0); chk("R9 payload", int'(v), 8'h91);
        bus_stop();
        host_pop(v);
        chk("R9 write before repeated START kept", int'(v), 8'h27);

        // R9: after STOP, an address without START gets no answer.
        send_byte({DEF_ADDR, 1'b0}, ack);
        chk("R9 no response without START", ack, 0);
        hold();

        chk("R10 SDA drive changed only with SCL low", r10_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule